// File: doc/BRIEF.md
# Receive Byte Buffer with Flow-Control Signalling

This block sits between a serial receiver and whatever consumes its bytes. Incoming bytes, offered one per cycle with a valid strobe, are stored in a small first-in first-out queue. The consumer sees the oldest stored byte and a valid flag, and removes it with a pop strobe. A byte that arrives while the queue is completely full and not being drained is thrown away, and a one-cycle overrun pulse marks the loss.

The block also tells the remote sender to pause and resume, using two programmable fill levels with hysteresis between them. A two-bit mode input picks the method. In pin mode the ready-to-receive output drops while the sender should pause. In in-band mode the block asks a nearby transmitter to send a stop character (0x13) or a go character (0x11). Each such request is held until the transmitter acknowledges it. In off mode the ready output stays high and no character is ever requested.

Top module: `rxfc_buffer`

## Requirements
- R1: After synchronous reset, fill level is 0, rd_valid is 0, rts is 1, xchar_req is 0 and ovr_pulse is 0.
- R2: Bytes leave in arrival order. rd_byte shows the oldest stored byte whenever rd_valid is 1. fill_level changes one clock edge after an accepted push or pop, and never exceeds DEPTH.
- R3: A byte offered while fill_level equals DEPTH, with no pop in the same cycle, is discarded and leaves the stored contents unchanged. ovr_pulse is high for exactly the one cycle that follows that edge.
- R4: A push and a pop in the same cycle while full both succeed. There is no overrun, fill_level stays at DEPTH, and the new byte is queued behind the others.
- R5: In pin mode (fc_mode = 1), rts goes low one edge after fill_level first becomes greater than or equal to stop_level, and not before.
- R6: In pin mode, once low, rts stays low while fill_level is above resume_level. It returns high one edge after fill_level becomes less than or equal to resume_level (stop_level > resume_level).
- R7: In in-band mode (fc_mode = 2), crossing stop_level raises xchar_req with xchar_code = 0x13 one edge after the level change. The request stays high until xchar_ack is seen, and it is issued only once per crossing.
- R8: In in-band mode, falling to resume_level or below after a stop request raises xchar_req with xchar_code = 0x11, held until acknowledged.
- R9: rts is low only in pin mode. In off mode (fc_mode = 0, with 3 treated the same) and in in-band mode, rts stays 1. In any mode other than in-band, xchar_req is 0 from the next edge on.
- R10: A pop while the buffer is empty is ignored: fill_level stays 0 and rd_valid stays 0.
- R11: xchar_ack clears a pending request at the next edge. An acknowledge with no pending request has no effect, and xchar_req stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is offered this cycle |
| rx_byte | input | W | Received byte |
| rd_pop | input | 1 | Consumer removes the head byte |
| rd_valid | output | 1 | Buffer holds at least one byte |
| rd_byte | output | W | Oldest stored byte |
| fill_level | output | CW | Number of stored bytes |
| ovr_pulse | output | 1 | One-cycle pulse: a byte was dropped |
| fc_mode | input | 2 | 0 off, 1 pin, 2 in-band, 3 off |
| stop_level | input | CW | Fill level at which the sender is paused |
| resume_level | input | CW | Fill level at or below which the sender may resume |
| rts | output | 1 | Ready to receive, toward the remote sender |
| xchar_req | output | 1 | Request for the local transmitter to send a character |
| xchar_code | output | 8 | Character to send (0x13 stop, 0x11 go) |
| xchar_ack | input | 1 | Transmitter has taken the request |

## Verification
fill_level, rd_valid and rd_byte move one edge after the cycle in which a push or pop is presented. ovr_pulse appears after that same edge and is gone one edge later. rts and xchar_req lag fill_level by one further edge, because the pause state is registered from the stored level. The bench drives inputs and samples outputs on falling edges. After each push or pop it reads fill_level and the old flow-control value, then waits one idle cycle and reads the new flow-control value, so both an early change and a missing change are caught. Every pair of stop and resume levels with stop above resume is swept in both pin and in-band modes, and the expected pause state is derived from the level arithmetic.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

    typedef enum logic [1:0] {
        FCM_OFF    = 2'd0,
        FCM_PIN    = 2'd1,
        FCM_INBAND = 2'd2,
        FCM_SPARE  = 2'd3
    } fc_mode_e;

    localparam logic [7:0] CH_STOP = 8'h13;
    localparam logic [7:0] CH_GO   = 8'h11;

    typedef struct packed {
        logic       pend;
        logic [7:0] code;
    } ch_req_t;

    // Hysteresis: pause at or above stop, release at or below resume.
    function automatic logic pause_next(input logic cur,
                                        input int unsigned lvl,
                                        input int unsigned stop,
                                        input int unsigned resume);
        if (!cur && lvl >= stop)
            return 1'b1;
        else if (cur && lvl <= resume)
            return 1'b0;
        else
            return cur;
    endfunction

endpackage

// File: rtl/rxfc_fifo.sv
module rxfc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_req,
    input  logic [W-1:0]  push_data,
    input  logic          pop_req,
    output logic [W-1:0]  head_data,
    output logic [CW-1:0] level,
    output logic          empty,
    output logic          full,
    output logic          drop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          push_ok;
    logic          pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign empty     = (level == '0);
    assign full      = (level == CW'(DEPTH));
    assign pop_ok    = pop_req && !empty;
    assign push_ok   = push_req && (!full || pop_ok);
    assign head_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            drop   <= 1'b0;
        end else begin
            drop <= push_req && !push_ok;
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/rxfc_ctrl.sv
module rxfc_ctrl
    import rxfc_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  fc_mode_e      mode,
    input  logic [CW-1:0] level,
    input  logic [CW-1:0] stop_lvl,
    input  logic [CW-1:0] resume_lvl,
    input  logic          ack,
    output logic          rts,
    output ch_req_t       req
);
    logic pause_q;
    logic pause_d;

    assign pause_d = pause_next(pause_q, 32'(level), 32'(stop_lvl), 32'(resume_lvl));
    assign rts     = !((mode == FCM_PIN) && pause_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pause_q <= 1'b0;
            req     <= '0;
        end else begin
            pause_q <= pause_d;
            if (mode != FCM_INBAND) begin
                req.pend <= 1'b0;
            end else if (pause_d != pause_q) begin
                req.pend <= 1'b1;
                req.code <= pause_d ? CH_STOP : CH_GO;
            end else if (ack) begin
                req.pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rxfc_buffer.sv
module rxfc_buffer
    import rxfc_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_valid,
    input  logic [W-1:0]  rx_byte,
    input  logic          rd_pop,
    output logic          rd_valid,
    output logic [W-1:0]  rd_byte,
    output logic [CW-1:0] fill_level,
    output logic          ovr_pulse,
    input  logic [1:0]    fc_mode,
    input  logic [CW-1:0] stop_level,
    input  logic [CW-1:0] resume_level,
    output logic          rts,
    output logic          xchar_req,
    output logic [7:0]    xchar_code,
    input  logic          xchar_ack
);
    logic    q_empty;
    logic    q_full;
    ch_req_t ch;

    rxfc_fifo #(.W(W), .DEPTH(DEPTH), .CW(CW)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push_req  (rx_valid),
        .push_data (rx_byte),
        .pop_req   (rd_pop),
        .head_data (rd_byte),
        .level     (fill_level),
        .empty     (q_empty),
        .full      (q_full),
        .drop      (ovr_pulse)
    );

    rxfc_ctrl #(.CW(CW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .mode       (fc_mode_e'(fc_mode)),
        .level      (fill_level),
        .stop_lvl   (stop_level),
        .resume_lvl (resume_level),
        .ack        (xchar_ack),
        .rts        (rts),
        .req        (ch)
    );

    assign rd_valid   = !q_empty;
    assign xchar_req  = ch.pend;
    assign xchar_code = ch.code;

    logic unused_full;
    assign unused_full = q_full;

endmodule

// File: rtl/rxfc_buffer_chk.sv
module rxfc_buffer_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_valid,
    input logic          rd_pop,
    input logic [CW-1:0] fill_level,
    input logic          ovr_pulse,
    input logic [1:0]    fc_mode,
    input logic          rts,
    input logic          xchar_req,
    input logic          xchar_ack
);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
        fill_level <= FULL_LVL);

    a_r3_drop_when_full: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rd_pop && fill_level == FULL_LVL) |=> (ovr_pulse && fill_level == FULL_LVL));

    a_r4_pushpop_full: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rd_pop && fill_level == FULL_LVL) |=> (!ovr_pulse && fill_level == FULL_LVL));

    a_r10_pop_empty: assert property (@(posedge clk) disable iff (rst)
        (rd_pop && !rx_valid && fill_level == '0) |=> (fill_level == '0));

    a_r9_rts_pin_only: assert property (@(posedge clk) disable iff (rst)
        !rts |-> (fc_mode == 2'd1));

    a_r9_no_req_outside_inband: assert property (@(posedge clk) disable iff (rst)
        (fc_mode != 2'd2) |=> !xchar_req);

    a_r7_req_held: assert property (@(posedge clk) disable iff (rst)
        (xchar_req && !xchar_ack && fc_mode == 2'd2) |=> xchar_req);

endmodule

bind rxfc_buffer rxfc_buffer_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .rd_pop     (rd_pop),
    .fill_level (fill_level),
    .ovr_pulse  (ovr_pulse),
    .fc_mode    (fc_mode),
    .rts        (rts),
    .xchar_req  (xchar_req),
    .xchar_ack  (xchar_ack)
);

// File: tb/rxfc_buffer_bench.sv
module rxfc_buffer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W     = 8;
    localparam int DEPTH = 8;
    localparam int CW    = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          rx_valid;
    logic [W-1:0]  rx_byte;
    logic          rd_pop;
    logic          rd_valid;
    logic [W-1:0]  rd_byte;
    logic [CW-1:0] fill_level;
    logic          ovr_pulse;
    logic [1:0]    fc_mode;
    logic [CW-1:0] stop_level;
    logic [CW-1:0] resume_level;
    logic          rts;
    logic          xchar_req;
    logic [7:0]    xchar_code;
    logic          xchar_ack;

    int vectors    = 0;
    int miscompares = 0;
    bit reported   = 1'b0;

    rxfc_buffer #(.W(W), .DEPTH(DEPTH)) u_rxfc_buffer (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rd_pop(rd_pop), .rd_valid(rd_valid), .rd_byte(rd_byte),
        .fill_level(fill_level), .ovr_pulse(ovr_pulse), .fc_mode(fc_mode),
        .stop_level(stop_level), .resume_level(resume_level), .rts(rts),
        .xchar_req(xchar_req), .xchar_code(xchar_code), .xchar_ack(xchar_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Present inputs for one rising edge, starting and ending on a falling edge.
    task automatic drive(input logic v, input logic [7:0] d, input logic p);
        rx_valid = v;
        rx_byte  = d;
        rd_pop   = p;
        tick();
        rx_valid = 1'b0;
        rd_pop   = 1'b0;
    endtask

    task automatic ack_once();
        xchar_ack = 1'b1;
        tick();
        xchar_ack = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        vectors++;
        miscompares++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        rst = 1'b1; rx_valid = 1'b0; rx_byte = '0; rd_pop = 1'b0;
        fc_mode = 2'd0; stop_level = CW'(DEPTH); resume_level = '0; xchar_ack = 1'b0;
        tick(); tick(); tick();
        rst = 1'b0;
        // R1 reset state
        chk("R1 level", int'(fill_level), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 rts", int'(rts), 1);
        chk("R1 xchar_req", int'(xchar_req), 0);
        chk("R1 ovr_pulse", int'(ovr_pulse), 0);

        // R10 pop on empty
        drive(1'b0, 8'h00, 1'b1);
        chk("R10 level", int'(fill_level), 0);
        chk("R10 rd_valid", int'(rd_valid), 0);

        // R2 ordering
        for (int i = 0; i < 5; i++) begin
            drive(1'b1, 8'hA0 + 8'(i), 1'b0);
            chk("R2 level up", int'(fill_level), i + 1);
        end
        for (int i = 0; i < 5; i++) begin
            chk("R2 rd_valid", int'(rd_valid), 1);
            chk("R2 head", int'(rd_byte), 'hA0 + i);
            drive(1'b0, 8'h00, 1'b1);
            chk("R2 level down", int'(fill_level), 4 - i);
        end

        // R3 overrun, R4 push+pop when full, R9 off mode
        for (int i = 0; i < DEPTH; i++) drive(1'b1, 8'h30 + 8'(i), 1'b0);
        chk("R2 full level", int'(fill_level), DEPTH);
        chk("R9 off rts", int'(rts), 1);
        chk("R9 off req", int'(xchar_req), 0);
        drive(1'b1, 8'hEE, 1'b0);
        chk("R3 ovr pulse", int'(ovr_pulse), 1);
        chk("R3 level held", int'(fill_level), DEPTH);
        tick();
        chk("R3 pulse one cycle", int'(ovr_pulse), 0);
        drive(1'b1, 8'h77, 1'b1);
        chk("R4 no overrun", int'(ovr_pulse), 0);
        chk("R4 level", int'(fill_level), DEPTH);
        for (int i = 1; i <= DEPTH; i++) begin
            chk("R3 R4 order", int'(rd_byte), (i < DEPTH) ? ('h30 + i) : 'h77);
            drive(1'b0, 8'h00, 1'b1);
        end
        chk("R2 drained", int'(fill_level), 0);
        tick();

        // Sweep of thresholds in pin (1) and in-band (2) modes
        for (int m = 1; m <= 2; m++) begin
            for (int s = 1; s <= DEPTH; s++) begin
                for (int r = 0; r < s; r++) begin
                    bit thr;
                    bit nthr;
                    fc_mode = 2'(m);
                    stop_level = CW'(s);
                    resume_level = CW'(r);
                    thr = 1'b0;
                    tick();
                    for (int l = 1; l <= DEPTH; l++) begin
                        drive(1'b1, 8'((s * 16 + r + l) & 255), 1'b0);
                        chk("R2 sweep level", int'(fill_level), l);
                        nthr = (l >= s) ? 1'b1 : thr;
                        if (m == 1) begin
                            chk("R5 rts not early", int'(rts), int'(!thr));
                            tick();
                            chk("R5 rts", int'(rts), int'(!nthr));
                        end else begin
                            chk("R7 not early", int'(xchar_req), 0);
                            tick();
                            chk("R9 inband rts", int'(rts), 1);
                            if (nthr && !thr) begin
                                chk("R7 xoff req", int'(xchar_req), 1);
                                chk("R7 xoff code", int'(xchar_code), 'h13);
                                tick();
                                chk("R7 held", int'(xchar_req), 1);
                                ack_once();
                                chk("R11 ack clears", int'(xchar_req), 0);
                            end else begin
                                chk("R7 once", int'(xchar_req), 0);
                            end
                        end
                        thr = nthr;
                    end
                    for (int l = DEPTH - 1; l >= 0; l--) begin
                        chk("R2 sweep head", int'(rd_byte), (s * 16 + r + (DEPTH - l)) & 255);
                        drive(1'b0, 8'h00, 1'b1);
                        chk("R2 sweep level", int'(fill_level), l);
                        nthr = (l <= r) ? 1'b0 : thr;
                        tick();
                        if (m == 1) begin
                            chk("R6 rts", int'(rts), int'(!nthr));
                        end else if (thr && !nthr) begin
                            chk("R8 xon req", int'(xchar_req), 1);
                            chk("R8 xon code", int'(xchar_code), 'h11);
                            ack_once();
                            chk("R11 ack clears", int'(xchar_req), 0);
                        end else begin
                            chk("R8 once", int'(xchar_req), 0);
                        end
                        thr = nthr;
                    end
                end
            end
        end

        // R11 ack without pending request
        fc_mode = 2'd2;
        tick();
        ack_once();
        chk("R11 stray ack", int'(xchar_req), 0);
        fc_mode = 2'd3;
        tick();
        chk("R9 mode3 rts", int'(rts), 1);

        report();
        $finish;
    end

endmodule